// File: doc/BRIEF.md
# Target Reset Line Pulse Controller

This block drives the active-low, open-drain system reset line of a target device from a clocked host. It takes one of three commands: a full pulse, assert only, or release only. A full pulse pulls the line low for a fixed hold time and then lets it go. Assert only pulls the line low and finishes at once. Release only lets the line go and runs the recovery step on its own. The block shows `busy` while a timed step is running, pulses `done` when a command finishes, and raises an error flag if the line never came back high.

The line is one bit of an 8-bit pin word. The block sets a pull-low enable for that bit and reads the same bit back from an 8-bit readback word. The elaboration parameter `READBACK_EN` picks one of two recovery variants:

- **With readback:** the block passes the pin level through a two-flop synchroniser. It waits until the pin reads high, or until a timeout ends.
- **Without readback:** the block waits a fixed recovery delay and reports done.

All times are counted in clock cycles. At 250 MHz the defaults give a 50 ms hold, a 1 s timeout and a 100 ms fixed recovery.

Top module: `rstp_ctrl`

## Requirements
- R1: After reset, `pin_drv_o` is all zero, and `busy_o`, `done_o` and `err_o` are all 0.
- R2: Command code 1 (pulse) is accepted when the block is idle. From the cycle after acceptance, `pin_drv_o[7]` is 1 (line pulled low) for exactly `HOLD_CYC` cycles. `busy_o` is 1 from the cycle after acceptance until the recovery step ends.
- R3: Command code 2 (assert) sets `pin_drv_o[7]` to 1 from the next cycle and keeps it there. It pulses `done_o` in that same next cycle, and `busy_o` does not rise.
- R4: Command code 3 (release) clears `pin_drv_o[7]` in the next cycle and then runs the recovery step. The full pulse enters the same recovery step at the end of its hold time. When recovery ends, the line is released.
- R5: With readback, recovery ends when bit 7 of `pin_rd_i` is seen high. Because of the two-flop synchroniser, a rise of that bit before clock edge e gives `done_o` after edge e+2.
- R6: With readback, if bit 7 of `pin_rd_i` is not seen high within `TIMEOUT_CYC` cycles of the release, `done_o` and `err_o` rise together. The line stays released and `busy_o` falls.
- R7: Without readback, `done_o` comes exactly `RECOVER_CYC` cycles after the release. In this variant `pin_rd_i` has no effect and `err_o` stays 0.
- R8: A command that arrives while `busy_o` is 1 is ignored, and so is code 0.
- R9: `done_o` is 1 only while `busy_o` is 0. `err_o` holds its value until the next command is accepted, which clears it.
- R10: The reset line sits at bit position 7 of the 8-bit drive and readback words. The other drive bits are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | Command code: 0 none, 1 pulse, 2 assert, 3 release |
| pin_rd_i | input | 8 | Pin readback word; bit 7 is the reset line level |
| pin_drv_o | output | 8 | Pull-low enables; bit 7 pulls the reset line low |
| busy_o | output | 1 | A timed step is running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Recovery timed out (held until the next command) |

## Verification
The hardest case to reach is a line that the target itself keeps low after the block has released it. That situation is needed both for a late recovery and for a timeout. The bench models the target as a second open-drain puller on the readback bit and holds it low through a release. It then either lets the line go partway through the wait, to check the synchroniser latency, or never lets it go, to force the timeout. Both variants are driven by the same commands, so the fixed-delay variant shows at the same moment that a stuck readback has no effect on it.

// File: rtl/rstp_pkg.sv
package rstp_pkg;

   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_PULSE   = 2'd1,
      OP_ASSERT  = 2'd2,
      OP_RELEASE = 2'd3
   } rstp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RECOVER = 2'd2
   } rstp_st_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rstp_sync.sv
module rstp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);
   initial begin
      if (STAGES < 2) $error("rstp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstp_cdown.sv
module rstp_cdown #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   initial begin
      if (W < 1) $error("rstp_cdown: W must be positive");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (load_i)        cnt_q <= val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   p_cnt_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rstp_ctrl.sv
module rstp_ctrl
   import rstp_pkg::*;
#(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned RST_BIT     = 7,
   parameter bit          READBACK_EN = 1'b1,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 12_500_000,
   parameter int unsigned TIMEOUT_CYC = 250_000_000,
   parameter int unsigned RECOVER_CYC = 25_000_000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmd_valid_i,
   input  logic [1:0]       cmd_op_i,
   input  logic [PIN_W-1:0] pin_rd_i,
   output logic [PIN_W-1:0] pin_drv_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int unsigned REC_CYC = READBACK_EN ? TIMEOUT_CYC : RECOVER_CYC;
   localparam int unsigned MAX_CYC = max3(HOLD_CYC, TIMEOUT_CYC, RECOVER_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

   initial begin
      if (RST_BIT >= PIN_W) $error("rstp_ctrl: RST_BIT outside pin word");
      if (HOLD_CYC < 1)     $error("rstp_ctrl: HOLD_CYC must be at least 1");
      if (REC_CYC < 1)      $error("rstp_ctrl: recovery count must be at least 1");
   end

   rstp_st_e         st_q;
   logic             line_low_q, done_q, err_q;
   logic             tmr_load, tmr_zero, rb_high, accept;
   logic [CNT_W-1:0] tmr_val;
   rstp_op_e         op;

   assign op     = rstp_op_e'(cmd_op_i);
   assign accept = (st_q == ST_IDLE) && cmd_valid_i && (op != OP_NONE);

   // readback path: present only when the level can be read
   generate
      if (READBACK_EN) begin : g_rb
         rstp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .async_i(pin_rd_i[RST_BIT]),
            .sync_o (rb_high)
         );
      end else begin : g_no_rb
         assign rb_high = 1'b0;
         p_no_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) !err_o);
      end
   endgenerate

   rstp_cdown #(.W(CNT_W)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(tmr_load),
      .val_i (tmr_val),
      .zero_o(tmr_zero)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (accept && op == OP_PULSE) begin
         tmr_load = 1'b1;
         tmr_val  = HOLD_LD;
      end else if (accept && op == OP_RELEASE) begin
         tmr_load = 1'b1;
         tmr_val  = REC_LD;
      end else if (st_q == ST_HOLD && tmr_zero) begin
         tmr_load = 1'b1;
         tmr_val  = REC_LD;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q       <= ST_IDLE;
         line_low_q <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               err_q <= 1'b0;
               unique case (op)
                  OP_PULSE: begin
                     line_low_q <= 1'b1;
                     st_q       <= ST_HOLD;
                  end
                  OP_ASSERT: begin
                     line_low_q <= 1'b1;
                     done_q     <= 1'b1;
                  end
                  default: begin
                     line_low_q <= 1'b0;
                     st_q       <= ST_RECOVER;
                  end
               endcase
            end
            ST_HOLD: if (tmr_zero) begin
               line_low_q <= 1'b0;
               st_q       <= ST_RECOVER;
            end
            ST_RECOVER: begin
               if (rb_high) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (tmr_zero) begin
                  done_q <= 1'b1;
                  err_q  <= READBACK_EN;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar b = 0; b < PIN_W; b++) begin : g_drv
         if (b == RST_BIT) begin : g_line
            assign pin_drv_o[b] = line_low_q;
         end else begin : g_idle
            assign pin_drv_o[b] = 1'b0;
         end
      end
   endgenerate

   assign busy_o = (st_q != ST_IDLE);
   assign done_o = done_q;
   assign err_o  = err_q;

   p_hold_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_HOLD) |-> pin_drv_o[RST_BIT]);
   p_released_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && $past(busy_o)) |-> !pin_drv_o[RST_BIT]);
   p_err_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> done_o);
   p_start_by_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> ($past(cmd_valid_i) && !$past(busy_o)));
   p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);
   p_err_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(!busy_o) && !$past(cmd_valid_i)) |-> $stable(err_o));
endmodule

// File: tb/rstp_ctrl_tb_top.sv
module rstp_ref_model #(
   parameter bit          RB      = 1'b1,
   parameter int unsigned HOLD    = 20,
   parameter int unsigned REC     = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic [1:0] op,
   input  logic       rd,
   output logic       e_low,
   output logic       e_busy,
   output logic       e_done,
   output logic       e_err
);
   int  phase;   // 0 idle, 1 holding, 2 recovering
   int  left;
   bit  seen_q[$];

   always @(posedge clk) begin
      bit seen;
      if (!rst_n) begin
         phase = 0; left = 0; e_low = 0; e_busy = 0; e_done = 0; e_err = 0;
         seen_q = '{0, 0};
      end else begin
         seen = seen_q.pop_front();
         seen_q.push_back(rd);
         e_done = 0;
         if (phase == 0) begin
            if (valid && op != 2'd0) begin
               e_err = 0;
               if (op == 2'd1) begin e_low = 1; phase = 1; left = HOLD - 1; end
               else if (op == 2'd2) begin e_low = 1; e_done = 1; end
               else begin e_low = 0; phase = 2; left = REC - 1; end
            end
         end else if (phase == 1) begin
            if (left == 0) begin e_low = 0; phase = 2; left = REC - 1; end
            else left--;
         end else begin
            if (RB && seen) begin e_done = 1; phase = 0; end
            else if (left == 0) begin e_done = 1; e_err = RB; phase = 0; end
            else left--;
         end
         e_busy = (phase != 0);
      end
   end
endmodule

module rstp_ctrl_tb_top;
   localparam int unsigned HOLD = 20, TMO = 40, RCV = 15;

   logic       clk = 0, rst_n = 0, valid = 0;
   logic [1:0] op = 0;
   logic       tgt_stuck = 0;
   logic [7:0] drv_a, drv_b, rd_a, rd_b;
   logic       busy_a, done_a, err_a, busy_b, done_b, err_b;
   logic       ea_low, ea_busy, ea_done, ea_err, eb_low, eb_busy, eb_done, eb_err;
   int         total = 0, bad = 0, cyc = 0;
   bit         finished = 0;

   always #2 clk = ~clk;

   assign rd_a = {~(drv_a[7] | tgt_stuck), 7'h7F};
   assign rd_b = {~(drv_b[7] | tgt_stuck), 7'h7F};

   rstp_ctrl #(.READBACK_EN(1'b1), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO), .RECOVER_CYC(RCV)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op), .pin_rd_i(rd_a),
      .pin_drv_o(drv_a), .busy_o(busy_a), .done_o(done_a), .err_o(err_a));
   rstp_ctrl #(.READBACK_EN(1'b0), .HOLD_CYC(HOLD), .TIMEOUT_CYC(TMO), .RECOVER_CYC(RCV)) dut_fix_i (
      .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_op_i(op), .pin_rd_i(rd_b),
      .pin_drv_o(drv_b), .busy_o(busy_b), .done_o(done_b), .err_o(err_b));

   rstp_ref_model #(.RB(1'b1), .HOLD(HOLD), .REC(TMO)) ref_a (
      .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .rd(rd_a[7]),
      .e_low(ea_low), .e_busy(ea_busy), .e_done(ea_done), .e_err(ea_err));
   rstp_ref_model #(.RB(1'b0), .HOLD(HOLD), .REC(RCV)) ref_b (
      .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .rd(rd_b[7]),
      .e_low(eb_low), .e_busy(eb_busy), .e_done(eb_done), .e_err(eb_err));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the reference models
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2/R3/R4 readback line", drv_a, {ea_low, 7'b0});
         chk("R9 readback busy", busy_a, ea_busy);
         chk("R5/R9 readback done", done_a, ea_done);
         chk("R6 readback err", err_a, ea_err);
         chk("R10 fixed line", drv_b, {eb_low, 7'b0});
         chk("R8 fixed busy", busy_b, eb_busy);
         chk("R7 fixed done", done_b, eb_done);
         chk("R7 fixed err", err_b, eb_err);
      end
   end

   task automatic issue(input logic [1:0] code);
      @(negedge clk); valid = 1; op = code;
      @(negedge clk); valid = 0; op = 0;
   endtask

   task automatic settle();
      while (busy_a || busy_b) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         summary();
      end
   end

   initial begin
      int width;
      repeat (3) @(negedge clk);
      chk("R1 drive", {drv_a, drv_b}, 16'h0);
      chk("R1 flags", {busy_a, done_a, err_a, busy_b, done_b, err_b}, 6'b0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2 full pulse, measure low width directly
      @(negedge clk); valid = 1; op = 2'd1;
      @(negedge clk); valid = 0; op = 0;
      width = 0;
      while (drv_a[7]) begin width++; chk("R2 busy in hold", busy_a, 1'b1); @(negedge clk); end
      chk("R2 hold width", width, HOLD);
      settle();

      // R8 code 0 ignored
      issue(2'd0);
      chk("R8 code0 ignored", {busy_a, drv_a[7], done_a}, 3'b0);

      // R3 assert only
      @(negedge clk); valid = 1; op = 2'd2;
      @(negedge clk); valid = 0; op = 0;
      chk("R3 line low", drv_a[7], 1'b1);
      chk("R3 done pulse", done_a, 1'b1);
      chk("R3 no busy", busy_a, 1'b0);
      repeat (5) @(negedge clk);
      chk("R3 line stays low", drv_a[7], 1'b1);

      // R4/R5 release while target keeps line low, then lets go
      tgt_stuck = 1;
      issue(2'd3);
      chk("R4 released", drv_a[7], 1'b0);
      repeat (8) @(negedge clk);
      tgt_stuck = 0;
      @(negedge clk); chk("R5 not yet", done_a, 1'b0);
      @(negedge clk); chk("R5 not yet", done_a, 1'b0);
      @(negedge clk); chk("R5 done after sync", done_a, 1'b1);
      chk("R5 no err", err_a, 1'b0);
      settle();

      // R8 commands during busy ignored
      issue(2'd1);
      repeat (4) @(negedge clk);
      issue(2'd3);
      chk("R8 release ignored in hold", drv_a[7], 1'b1);
      issue(2'd2);
      settle();

      // R6/R7 timeout with target stuck; fixed variant unaffected
      tgt_stuck = 1;
      issue(2'd3);
      while (!done_a) @(negedge clk);
      chk("R6 err with done", err_a, 1'b1);
      chk("R6 line released", drv_a[7], 1'b0);
      chk("R7 fixed no err", err_b, 1'b0);
      repeat (3) @(negedge clk);
      chk("R9 err held", err_a, 1'b1);
      tgt_stuck = 0;
      settle();
      issue(2'd2);
      chk("R9 err cleared", err_a, 1'b0);
      issue(2'd3);
      settle();

      finished = 1;
      summary();
   end
endmodule